// File: doc/BRIEF.md
# Zero-Current-Switching Pulse Width Tuner

This block sets how long the high-side rectifier switch of a discontinuous-mode synchronous boost converter stays on. It holds a small width code. After each high-side turn-off, a clocked comparator compares the switch node with the output rail and presents one decision bit together with a valid strobe. The tuner moves the code one step toward zero-current turn-off: it steps up when the pulse was too short and down when it was too long. A converter-rate clock drives the block, and there is no fast internal timing. Once settled, the code swaps between the two settings that bracket the ideal width.

A behavioural pulse generator is included so that the loop can be exercised. When the generator gets a cycle-start strobe, it turns the current code into a high-side gate pulse whose length is a whole number of clock cycles.

Top module: `zcs_width_tuner`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the width code is 4 (mid-range) and the gate output is low.
- R2: At a clock edge where the valid strobe is high and the decision bit is 1 (switch node above the output after turn-off, so the pulse was too short), the code increases by one.
- R3: At a clock edge where the valid strobe is high and the decision bit is 0, the code decreases by one.
- R4: The code saturates. An up step at 7 leaves it at 7, a down step at 0 leaves it at 0, and it never wraps.
- R5: At a clock edge where the valid strobe is low, the code keeps its value whatever the decision bit is.
- R6: A cycle-start strobe seen while the gate is low raises the gate at that edge. The gate then stays high for exactly MIN_CYC + code clock cycles (MIN_CYC defaults to 1). The code used is the value held just before that edge, even if a step lands on the same edge.
- R7: A cycle-start strobe seen while the gate is high does not lengthen or restart the pulse.
- R8: Suppose the ideal width lies between codes 5 and 6, so the decision is 1 exactly when the code is at most 5. From any starting code, after nine valid decisions the code is 5 or 6, and from then on it alternates between them on every decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Comparator decision is valid this cycle |
| cmp_above | input | 1 | 1 when the switch node was above the output after turn-off |
| cyc_start | input | 1 | Starts a high-side pulse in the behavioural generator |
| width_code | output | CODE_W (3) | Current pulse-width code |
| hs_gate | output | 1 | Behavioural high-side gate pulse |

## Verification
Two things can happen on the same edge: a width step and the start of a pulse. In that case the pulse has to be timed by the code held before the step, while the code register still takes the step. The bench raises the start strobe and a valid up decision in the same cycle. It then compares the gate length with the pre-step code and the code output with the post-step value, and a scoreboard predicts both cycle by cycle. A start strobe that arrives during a live pulse is also placed against a step, to show that the running pulse keeps its length.

// File: rtl/zcs_pkg.sv
// Shared types for the pulse-width tuner.
// Assumes: one step command per clock, decoded from the comparator strobe.
package zcs_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/zcs_decision_decode.sv
// Turns the comparator strobe and decision into a step command.
// Assumes: the decision is meaningful only while the valid strobe is high.
module zcs_decision_decode
    import zcs_pkg::*;
(
    input  logic  cmp_valid,
    input  logic  cmp_above,
    output step_e step
);
    // Pick up, down or hold from the sampled comparator bit.
    always_comb begin
        if (!cmp_valid)     step = STEP_HOLD;
        else if (cmp_above) step = STEP_UP;
        else                step = STEP_DOWN;
    end
endmodule

// File: rtl/zcs_code_stepper.sv
// Saturating up/down register that holds the width code.
// Assumes: at most one step per clock; the reset value fits in CODE_W bits.
module zcs_code_stepper
    import zcs_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int RST_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;
    localparam logic [CODE_W-1:0] CODE_BOT = '0;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RST_CODE);

    // Apply one saturating step per valid decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_RST;
        end else begin
            case (step)
                STEP_UP:   if (code != CODE_TOP) code <= code + 1'b1;
                STEP_DOWN: if (code != CODE_BOT) code <= code - 1'b1;
                default:   code <= code;
            endcase
        end
    end
endmodule

// File: rtl/zcs_pulse_gen.sv
// Behavioural high-side pulse generator for loop testing.
// Assumes: the pulse length is counted in whole clocks, MIN_CYC >= 1;
// the code is captured at the start edge.
module zcs_pulse_gen #(
    parameter int CODE_W  = 3,
    parameter int MIN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              gate
);
    localparam int MAX_LEN = MIN_CYC + (1 << CODE_W) - 1;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] remain;

    // Launch a pulse when idle, then count it down to turn-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate   <= 1'b0;
            remain <= '0;
        end else if (!gate) begin
            if (start) begin
                gate   <= 1'b1;
                remain <= CNT_W'(MIN_CYC - 1) + CNT_W'(code);
            end
        end else if (remain == '0) begin
            gate <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/zcs_width_tuner.sv
// Top: zero-current-switching width tuner with a behavioural gate pulse.
// Assumes: the comparator result arrives after high-side turn-off with a
// one-clock valid strobe; all inputs are synchronous to clk.
module zcs_width_tuner
    import zcs_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int RST_CODE = 4,
    parameter int MIN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic              cmp_above,
    input  logic              cyc_start,
    output logic [CODE_W-1:0] width_code,
    output logic              hs_gate
);
    step_e step;

    zcs_decision_decode u_dec (
        .cmp_valid (cmp_valid),
        .cmp_above (cmp_above),
        .step      (step)
    );

    zcs_code_stepper #(
        .CODE_W   (CODE_W),
        .RST_CODE (RST_CODE)
    ) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .code  (width_code)
    );

    zcs_pulse_gen #(
        .CODE_W  (CODE_W),
        .MIN_CYC (MIN_CYC)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .code  (width_code),
        .gate  (hs_gate)
    );
endmodule

// File: rtl/zcs_width_tuner_chk.sv
// Assertion checker for the width tuner, bound to the top module.
// Assumes: same clock and synchronous active-low reset as the top.
module zcs_width_tuner_chk #(
    parameter int CODE_W   = 3,
    parameter int RST_CODE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic              cmp_above,
    input logic              cyc_start,
    input logic [CODE_W-1:0] width_code,
    input logic              hs_gate
);
    localparam logic [CODE_W-1:0] TOP = '1;
    localparam logic [CODE_W-1:0] BOT = '0;
    localparam logic [CODE_W-1:0] MID = CODE_W'(RST_CODE);

    p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (width_code == MID && !hs_gate));

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_above && width_code != TOP)
            |=> width_code == CODE_W'($past(width_code) + 1'b1));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_above && width_code != BOT)
            |=> width_code == CODE_W'($past(width_code) - 1'b1));

    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_above && width_code == TOP) |=> width_code == TOP);

    p_sat_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_above && width_code == BOT) |=> width_code == BOT);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(width_code));

    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !hs_gate) |=> hs_gate);
endmodule

bind zcs_width_tuner zcs_width_tuner_chk #(
    .CODE_W   (CODE_W),
    .RST_CODE (RST_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_above  (cmp_above),
    .cyc_start  (cyc_start),
    .width_code (width_code),
    .hs_gate    (hs_gate)
);

// File: tb/zcs_width_tuner_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts code and gate per cycle, and the
// monitor compares them one clock later, away from the edge.
module zcs_width_tuner_tb_top;
    localparam int CODE_W   = 3;
    localparam int RST_CODE = 4;
    localparam int MIN_CYC  = 1;
    localparam int CODE_TOP = (1 << CODE_W) - 1;
    localparam int IDEAL_LO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_valid = 1'b0;
    logic cmp_above = 1'b0;
    logic cyc_start = 1'b0;
    logic [CODE_W-1:0] width_code;
    logic hs_gate;

    typedef struct {
        int    code;
        bit    gate;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int n_vec = 0;
    int n_bad = 0;
    int m_code = RST_CODE;
    int m_cnt = 0;
    bit m_gate = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    zcs_width_tuner #(
        .CODE_W   (CODE_W),
        .RST_CODE (RST_CODE),
        .MIN_CYC  (MIN_CYC)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (cmp_valid),
        .cmp_above  (cmp_above),
        .cyc_start  (cyc_start),
        .width_code (width_code),
        .hs_gate    (hs_gate)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop one prediction per clock and compare both outputs.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            check({e.tag, " code"}, int'(width_code), e.code);
            check({e.tag, " gate"}, int'(hs_gate), int'(e.gate));
        end
    end

    // Driver: apply one cycle of stimulus and push the predicted result.
    task automatic cyc(input bit v, input bit a, input bit s, input bit plant,
                       input string tag);
        exp_t e;
        int   old;
        @(negedge clk);
        if (plant) a = (int'(width_code) <= IDEAL_LO);
        cmp_valid = v;
        cmp_above = a;
        cyc_start = s;
        old = m_code;
        if (!m_gate) begin
            if (s) begin
                m_gate = 1'b1;
                m_cnt  = MIN_CYC - 1 + old;
            end
        end else if (m_cnt == 0) begin
            m_gate = 1'b0;
        end else begin
            m_cnt--;
        end
        if (v && a && m_code < CODE_TOP) m_code++;
        else if (v && !a && m_code > 0) m_code--;
        e.code = m_code;
        e.gate = m_gate;
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmp_valid = 1'b0;
        cmp_above = 1'b0;
        cyc_start = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset code", int'(width_code), RST_CODE);
        check("R1 reset gate", int'(hs_gate), 0);
        rst_n  = 1'b1;
        m_code = RST_CODE;
        m_gate = 1'b0;
        m_cnt  = 0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1 first cycle after reset");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R5: no valid strobe, decision toggled, code must hold
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R5 hold above");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R5 hold below");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R5 hold above again");

        // R2 step up, then R4 saturate at the top
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, "R2 step up");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, "R4 saturate top");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, "R4 saturate top again");

        // R3 step down, then R4 saturate at the bottom
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R3 step down");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R4 saturate bottom");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R4 saturate bottom again");

        // R6: pulse at code 0, then code 3
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R6 pulse code 0");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6 idle after short pulse");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, "R2 step up to 3");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R6 pulse code 3");
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6 pulse length");

        // R6: start on the same edge as an up step uses the old code
        cyc(1'b1, 1'b1, 1'b1, 1'b0, "R6 start with step");
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6 pre-step length");

        // R7: restart attempts during a live pulse, one coinciding with a step
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R7 launch");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R7 start while busy");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, "R7 start while busy with step");
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R7 pulse unchanged");

        // R8: closed loop from every initial code
        for (int init = 0; init <= CODE_TOP; init++) begin
            int prev;
            int cur;
            do_reset();
            while (m_code != init)
                cyc(1'b1, (m_code < init), 1'b0, 1'b0, "R8 walk to initial code");
            for (int k = 0; k < 8; k++) cyc(1'b1, 1'b0, 1'b0, 1'b1, "R8 closed loop");
            prev = -1;
            for (int k = 0; k < 5; k++) begin
                cyc(1'b1, 1'b0, 1'b0, 1'b1, "R8 settled loop");
                @(posedge clk);
                #1;
                cur = int'(width_code);
                check("R8 code in settled pair", int'(cur == IDEAL_LO || cur == IDEAL_LO + 1), 1);
                if (prev >= 0) check("R8 code alternates", int'(cur != prev), 1);
                prev = cur;
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule